// File: doc/BRIEF.md
# Bit-Manipulation Count and Logic Unit

This block is a purely combinational execution unit for a 64-bit integer core. It takes an operation select, two operands, a word-form flag, a rotate amount and an enable for the bit-manipulation group. In the same cycle it returns a 64-bit result and a flag that marks the request as an illegal instruction.

The operations are:
- leading-zero count, trailing-zero count and set-bit count, each in a full-width form and a low-word form;
- AND and OR with the second operand inverted, and XNOR;
- signed and unsigned minimum and maximum;
- byte and halfword sign extension, and halfword zero extension;
- left and right rotates, in full-width and low-word forms;
- byte-order reversal;
- a per-byte OR reduction that fills each nonzero byte with ones.

Instruction decode, register reads and pipeline staging belong to the surrounding core.

Top module: `bit_manip_unit`

## Requirements
- R1: The full-width leading-zero count (code 0) and trailing-zero count (code 1) return the number of zero bits above the highest one, or below the lowest one, of `src_a`. Both return 64 when `src_a` is zero.
- R2: With `word_op` set, the leading-zero count looks only at `src_a[31:0]` and returns 32 when those bits are all zero.
- R3: With `word_op` set, the trailing-zero count treats bits 63:32 as ones, so a zero low word gives 32.
- R4: The set-bit count (code 2) counts the ones of all 64 bits, or only of bits 31:0 when `word_op` is set.
- R5: Code 3 gives `a & ~b`, code 4 gives `a | ~b` and code 5 gives `~(a ^ b)`.
- R6: Codes 6 and 7 return the signed minimum and maximum of the two operands. Codes 8 and 9 return the unsigned minimum and maximum.
- R7: Code 10 sign-extends from bit 7 and code 11 sign-extends from bit 15. Code 12 keeps bits 15:0 and clears bits 63:16.
- R8: Code 13 rotates `src_a` left and code 14 rotates it right, by `rot_amt` (6 bits), over all 64 bits.
- R9: With `word_op` set, the rotates act on bits 31:0 only and use `rot_amt[4:0]`. Bit 31 of the rotated word is copied into bits 63:32.
- R10: Code 15 reverses the order of the eight bytes of `src_a`.
- R11: Code 16 turns each byte of `src_a` that holds any one into 0xFF and leaves each zero byte as 0x00.
- R12: With `ext_en` low, every code raises `illegal`. Whenever `illegal` is high, `result` is zero.
- R13: The unit also raises `illegal` in two further cases, and `result` is then zero:
  - an undefined code (17 to 31);
  - `word_op` set with any code other than 0, 1, 2, 13 or 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code, values 0 to 16 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand (logic and min/max operations) |
| word_op | input | 1 | Selects the low-word form of counts and rotates |
| rot_amt | input | 6 | Rotate distance |
| ext_en | input | 1 | Enable for the bit-manipulation group |
| result | output | 64 | Operation result, zero when illegal |
| illegal | output | 1 | Request is not executable |

## Verification
The bench builds the unit with the default width of 64, so the half-word boundary sits at bit 32 and there are eight bytes. At this width the word forms can be driven with nonzero upper halves, which shows that the counts and rotates ignore those bits. All-zero, all-one and single-bit operands reach the count limits of 32 and 64. Rotate amounts of 0, 31, 32 and 63 exercise the wrap of the 5-bit and 6-bit distances. Operands with zero bytes mixed in are generated alongside dense random values, so the byte reversal and per-byte OR reduction see both kinds of byte.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_CLZ   = 5'd0,
        OP_CTZ   = 5'd1,
        OP_CPOP  = 5'd2,
        OP_ANDN  = 5'd3,
        OP_ORN   = 5'd4,
        OP_XNOR  = 5'd5,
        OP_MIN   = 5'd6,
        OP_MAX   = 5'd7,
        OP_MINU  = 5'd8,
        OP_MAXU  = 5'd9,
        OP_SEXTB = 5'd10,
        OP_SEXTH = 5'd11,
        OP_ZEXTH = 5'd12,
        OP_ROL   = 5'd13,
        OP_ROR   = 5'd14,
        OP_REV8  = 5'd15,
        OP_ORCB  = 5'd16
    } bmu_op_e;

    typedef enum logic [1:0] {
        GRP_COUNT,
        GRP_ROTATE,
        GRP_LOGIC
    } bmu_grp_e;

    typedef struct packed {
        logic     defined;
        logic     word_ok;
        bmu_grp_e grp;
    } bmu_dec_t;

    function automatic bmu_dec_t bmu_decode(input logic [OPW-1:0] code);
        bmu_dec_t d;
        d.defined = (code <= OP_ORCB);
        d.word_ok = 1'b0;
        d.grp     = GRP_LOGIC;
        case (code)
            OP_CLZ, OP_CTZ, OP_CPOP: begin
                d.grp     = GRP_COUNT;
                d.word_ok = 1'b1;
            end
            OP_ROL, OP_ROR: begin
                d.grp     = GRP_ROTATE;
                d.word_ok = 1'b1;
            end
            default: d.grp = GRP_LOGIC;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bmu_count.sv
module bmu_count
    import bmu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  bmu_op_e                    op,
    input  logic                       word,
    input  logic [XLEN-1:0]            operand,
    output logic [$clog2(XLEN):0]      count
);
    localparam int CW   = $clog2(XLEN) + 1;
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] staged;
    logic [XLEN-1:0] scan;
    logic [CW-1:0]   zeros;
    logic [CW-1:0]   ones;

    // Word forms pad the upper half so the scan stops at the half boundary.
    always_comb begin
        case (op)
            OP_CLZ:  staged = word ? {operand[HALF-1:0], {HALF{1'b1}}} : operand;
            OP_CTZ:  staged = word ? {{HALF{1'b1}}, operand[HALF-1:0]} : operand;
            default: staged = word ? {{HALF{1'b0}}, operand[HALF-1:0]} : operand;
        endcase
    end

    // Leading count is a trailing count of the mirrored vector.
    for (genvar g = 0; g < XLEN; g++) begin : g_mirror
        assign scan[g] = (op == OP_CLZ) ? staged[XLEN-1-g] : staged[g];
    end

    always_comb begin
        zeros = CW'(XLEN);
        ones  = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (scan[i]) zeros = CW'(i);
            ones = ones + CW'(scan[i]);
        end
        count = (op == OP_CPOP) ? ones : zeros;
    end

    always_comb begin
        if (op == OP_CTZ && !word) begin
            if (count < CW'(XLEN)) begin
                // R1
                ctz_hit_chk: assert (operand[count[CW-2:0]]);
            end else begin
                // R1
                ctz_empty_chk: assert (operand == '0);
            end
        end
        if (op == OP_CLZ && !word && count < CW'(XLEN)) begin
            // R1
            clz_hit_chk: assert (operand[XLEN-1-int'(count)]);
        end
        if (op == OP_CPOP && word) begin
            // R4
            cpop_word_range_chk: assert (count <= CW'(HALF));
        end
    end

endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
    parameter int XLEN = 64
) (
    input  logic                    left,
    input  logic                    word,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  logic [XLEN-1:0]         operand,
    output logic [XLEN-1:0]         rotated
);
    localparam int SW   = $clog2(XLEN);
    localparam int HALF = XLEN / 2;

    logic [SW-1:0]     sh_full;
    logic [SW-2:0]     sh_word;
    logic [2*XLEN-1:0] dbl_full;
    logic [XLEN-1:0]   dbl_word;

    // A left rotate is a right rotate by the two's complement distance.
    assign sh_full  = left ? (~amt + 1'b1) : amt;
    assign sh_word  = left ? (~amt[SW-2:0] + 1'b1) : amt[SW-2:0];
    assign dbl_full = {operand, operand} >> sh_full;
    assign dbl_word = {operand[HALF-1:0], operand[HALF-1:0]} >> sh_word;

    assign rotated = word ? {{HALF{dbl_word[HALF-1]}}, dbl_word[HALF-1:0]}
                          : dbl_full[XLEN-1:0];

    always_comb begin
        if (!word) begin
            // R8
            rot_pop_keep_chk: assert ($countones(rotated) == $countones(operand));
        end else begin
            // R9
            rotw_pop_keep_chk: assert ($countones(rotated[HALF-1:0]) ==
                                       $countones(operand[HALF-1:0]));
        end
    end

endmodule

// File: rtl/bmu_logic.sv
module bmu_logic
    import bmu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  bmu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] out
);
    localparam int NB = XLEN / 8;

    logic [XLEN-1:0] swapped;
    logic [XLEN-1:0] combined;
    logic            lt_s;
    logic            lt_u;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign swapped[8*g +: 8]  = a[8*(NB-1-g) +: 8];
        assign combined[8*g +: 8] = {8{|a[8*g +: 8]}};
    end

    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;

    always_comb begin
        case (op)
            OP_ANDN:  out = a & ~b;
            OP_ORN:   out = a | ~b;
            OP_XNOR:  out = ~(a ^ b);
            OP_MIN:   out = lt_s ? a : b;
            OP_MAX:   out = lt_s ? b : a;
            OP_MINU:  out = lt_u ? a : b;
            OP_MAXU:  out = lt_u ? b : a;
            OP_SEXTB: out = {{(XLEN-8){a[7]}}, a[7:0]};
            OP_SEXTH: out = {{(XLEN-16){a[15]}}, a[15:0]};
            OP_ZEXTH: out = {{(XLEN-16){1'b0}}, a[15:0]};
            OP_REV8:  out = swapped;
            OP_ORCB:  out = combined;
            default:  out = '0;
        endcase
    end

    always_comb begin
        if (op == OP_MIN) begin
            // R6
            min_bound_chk: assert ($signed(out) <= $signed(a) && $signed(out) <= $signed(b));
        end
        if (op == OP_MAXU) begin
            // R6
            maxu_bound_chk: assert (out >= a && out >= b);
        end
        if (op == OP_ORCB) begin
            for (int k = 0; k < NB; k++) begin
                // R11
                orc_byte_form_chk: assert (out[8*k +: 8] == 8'h00 || out[8*k +: 8] == 8'hFF);
            end
        end
    end

endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit
    import bmu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0]              op_sel,
    input  logic [XLEN-1:0]         src_a,
    input  logic [XLEN-1:0]         src_b,
    input  logic                    word_op,
    input  logic [$clog2(XLEN)-1:0] rot_amt,
    input  logic                    ext_en,
    output logic [XLEN-1:0]         result,
    output logic                    illegal
);
    localparam int CW = $clog2(XLEN) + 1;

    bmu_op_e         op;
    bmu_dec_t        dec;
    logic [CW-1:0]   cnt_val;
    logic [XLEN-1:0] rot_val;
    logic [XLEN-1:0] log_val;
    logic [XLEN-1:0] picked;

    assign op  = bmu_op_e'(op_sel);
    assign dec = bmu_decode(op_sel);

    bmu_count #(.XLEN(XLEN)) u_count (
        .op      (op),
        .word    (word_op),
        .operand (src_a),
        .count   (cnt_val)
    );

    bmu_rotate #(.XLEN(XLEN)) u_rotate (
        .left    (op == OP_ROL),
        .word    (word_op),
        .amt     (rot_amt),
        .operand (src_a),
        .rotated (rot_val)
    );

    bmu_logic #(.XLEN(XLEN)) u_logic (
        .op  (op),
        .a   (src_a),
        .b   (src_b),
        .out (log_val)
    );

    always_comb begin
        case (dec.grp)
            GRP_COUNT:  picked = XLEN'(cnt_val);
            GRP_ROTATE: picked = rot_val;
            default:    picked = log_val;
        endcase
    end

    assign illegal = !ext_en || !dec.defined || (word_op && !dec.word_ok);
    assign result  = illegal ? '0 : picked;

endmodule

// File: tb/tb_bit_manip_unit.sv
module tb_bit_manip_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_sel = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        word_op = 1'b0;
    logic [5:0]  rot_amt = '0;
    logic        ext_en = 1'b0;
    logic [63:0] result;
    logic        illegal;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    bit_manip_unit dut (
        .op_sel  (op_sel),
        .src_a   (src_a),
        .src_b   (src_b),
        .word_op (word_op),
        .rot_amt (rot_amt),
        .ext_en  (ext_en),
        .result  (result),
        .illegal (illegal)
    );

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic string tag_of(int op, bit w, bit en);
        if (!en) return "R12";
        if (op > 16) return "R13";
        if (w && !(op == 0 || op == 1 || op == 2 || op == 13 || op == 14)) return "R13";
        case (op)
            0:       return w ? "R2" : "R1";
            1:       return w ? "R3" : "R1";
            2:       return "R4";
            3, 4, 5: return "R5";
            6, 7, 8, 9: return "R6";
            10, 11, 12: return "R7";
            13, 14:  return w ? "R9" : "R8";
            15:      return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model(input int op, input logic [63:0] a, input logic [63:0] b,
                         input bit w, input int amt, input bit en,
                         output logic [63:0] r, output bit ill);
        int n;
        int top;
        int len;
        int s;
        bit found;
        logic [63:0] t;
        ill = !en || op > 16 ||
              (w && !(op == 0 || op == 1 || op == 2 || op == 13 || op == 14));
        r = '0;
        if (ill) return;
        top = w ? 31 : 63;
        case (op)
            0: begin
                n = 0; found = 0;
                for (int i = top; i >= 0; i--) begin
                    if (!found) begin
                        if (a[i]) found = 1; else n++;
                    end
                end
                r = 64'(n);
            end
            1: begin
                n = 0; found = 0;
                for (int i = 0; i <= top; i++) begin
                    if (!found) begin
                        if (a[i]) found = 1; else n++;
                    end
                end
                r = 64'(n);
            end
            2: begin
                n = 0;
                for (int i = 0; i <= top; i++) n += int'(a[i]);
                r = 64'(n);
            end
            3: r = a & ~b;
            4: r = a | ~b;
            5: r = ~(a ^ b);
            6: r = ($signed(a) < $signed(b)) ? a : b;
            7: r = ($signed(a) > $signed(b)) ? a : b;
            8: r = (a < b) ? a : b;
            9: r = (a > b) ? a : b;
            10: r = {{56{a[7]}}, a[7:0]};
            11: r = {{48{a[15]}}, a[15:0]};
            12: r = {48'h0, a[15:0]};
            13, 14: begin
                len = w ? 32 : 64;
                s = amt % len;
                t = '0;
                for (int k = 0; k < len; k++) begin
                    if (op == 14) t[k] = a[(k + s) % len];
                    else          t[(k + s) % len] = a[k];
                end
                r = w ? {{32{t[31]}}, t[31:0]} : t;
            end
            15: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
            default: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
        endcase
    endtask

    task automatic apply(input int op, input logic [63:0] a, input logic [63:0] b,
                         input bit w, input int amt, input bit en);
        logic [63:0] exp_r;
        bit exp_i;
        @(negedge clk);
        op_sel  = 5'(op);
        src_a   = a;
        src_b   = b;
        word_op = w;
        rot_amt = 6'(amt);
        ext_en  = en;
        model(op, a, b, w, amt, en, exp_r, exp_i);
        #5;
        vectors++;
        if (result !== exp_r || illegal !== exp_i) begin
            misses++;
            $display("FAIL %s op=%0d w=%0d amt=%0d en=%0d a=%h b=%h: got result=%h illegal=%b, expected result=%h illegal=%b",
                     tag_of(op, w, en), op, w, amt, en, a, b, result, illegal, exp_r, exp_i);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin : stimulus
        logic [63:0] ra;
        logic [63:0] rb;
        // Idle state under reset: group disabled (R12)
        repeat (3) @(posedge clk);
        apply(0, 64'h0, 64'h0, 0, 0, 0);
        rst = 1'b0;

        // R1 zero operand and single bits
        apply(0, 64'h0, 64'h0, 0, 0, 1);
        apply(1, 64'h0, 64'h0, 0, 0, 1);
        apply(0, 64'h8000_0000_0000_0000, 0, 0, 0, 1);
        apply(1, 64'h8000_0000_0000_0000, 0, 0, 0, 1);
        apply(0, 64'h1, 0, 0, 0, 1);
        // R2 word leading count, upper half ignored
        apply(0, 64'hFFFF_FFFF_0000_0000, 0, 1, 0, 1);
        apply(0, 64'hFFFF_FFFF_0000_0100, 0, 1, 0, 1);
        // R3 word trailing count
        apply(1, 64'hFFFF_FFFF_0000_0000, 0, 1, 0, 1);
        apply(1, 64'h0000_0000_8000_0000, 0, 1, 0, 1);
        // R4 counts
        apply(2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1);
        apply(2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 1);
        // R6 signed/unsigned differ
        apply(6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 1);
        apply(8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 1);
        apply(7, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 1);
        apply(9, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 1);
        // R7 extension edges
        apply(10, 64'h0000_0000_0000_0080, 0, 0, 0, 1);
        apply(11, 64'h1234_5678_9ABC_7FFF, 0, 0, 0, 1);
        apply(12, 64'hFFFF_FFFF_FFFF_8001, 0, 0, 0, 1);
        // R8 / R9 rotate boundaries
        apply(13, 64'h8000_0000_0000_0001, 0, 0, 63, 1);
        apply(14, 64'h8000_0000_0000_0001, 0, 0, 32, 1);
        apply(14, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 1);
        apply(13, 64'hDEAD_BEEF_4000_0000, 0, 1, 1, 1);
        apply(14, 64'h0000_0000_0000_0001, 0, 1, 32, 1);
        apply(14, 64'h0000_0000_0000_0001, 0, 1, 31, 1);
        // R10 / R11
        apply(15, 64'h0102_0304_0506_0708, 0, 0, 0, 1);
        apply(16, 64'h0080_0000_0100_FF00, 0, 0, 0, 1);
        // R13 undefined codes and misplaced word flag
        for (int c = 17; c < 32; c++) apply(c, 64'hFFFF, 64'h1, 0, 3, 1);
        for (int c = 3; c < 17; c++) begin
            if (c != 13 && c != 14) apply(c, 64'hF0F0, 64'h0F0F, 1, 3, 1);
        end
        // R12 disabled group, every code
        for (int c = 0; c < 17; c++) apply(c, 64'hA5A5_5A5A_0000_FFFF, 64'h3, 0, 5, 0);

        // Mixed patterns, sparse and dense
        for (int it = 0; it < 120; it++) begin
            for (int c = 0; c < 17; c++) begin
                ra = next_rand();
                rb = next_rand();
                if (it % 3 == 1) ra = ra & next_rand() & next_rand();
                if (it % 4 == 2) ra = ra & 64'hFF00_00FF_0000_FF00;
                if (it % 5 == 3) rb = ra;
                apply(c, ra, rb, (it % 2 == 1), int'(rb[5:0]), 1);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule